// File: doc/BRIEF.md
# Interleaved Microcode ROM Readout

This block models a mask-programmed microcode store that sits behind a micro-op sequencer. A single 9-bit address selects one entry, and the block returns three 72-bit micro-ops side by side on one 216-bit bus. The address is captured on a rising clock edge while the read enable is high. The three micro-ops appear on the bus during the following cycle and remain there until the next enabled read.

Inside, the store is built as two half-arrays that share one row address. The upper seven address bits choose a physical row: six bits pick one of 64 visible rows and one bit picks one of the two wordlines in that row. Each physical row holds four logical rows, interleaved column by column. For every block of 16 sensed columns, the two low address bits keep 4 columns and drop the other 12. The kept bits are caught in a per-column latch. They then pass through a fixed permutation that turns physical column order back into logical micro-op bit order.

Because of this, a user only ever sees words in logical order. The physical layout and the scramble permutation can be changed through parameters without changing the block's external contract.

Top module: `ucrom_top`

## Requirements
- R1: While `rstN` is low, `uopBus` is all zeros. After `rstN` rises, the bus stays zero until the first enabled read.
- R2: The address is split as {visible row[5:0], wordline bit, logical row[1:0]}, giving 512 distinct entries. When `readEn` is high at a rising edge, the entry at `addr` appears on `uopBus` after that edge and stays valid through the next cycle.
- R3: Every logical content bit reads back in logical order. For entry a and logical bit i (0 to 215), let h = a*37 + i*11 + ((a*i) mod 256) as a 32-bit integer. The bit equals the XOR of the bits of (h AND 0x1D3).
- R4: Micro-op k (k = 0, 1, 2) occupies `uopBus[72k+71:72k]`, with micro-op 0 in the lowest bits.
- R5: While `readEn` is low, `uopBus` keeps its last value whatever `addr` does.
- R6: Enabled reads on consecutive cycles deliver a new entry every cycle, with no idle cycle between them.
- R7: The four entries that share one physical row and differ only in the two low address bits each return their own logical row, never a neighbour's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all capture on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the column latches |
| readEn | input | 1 | Enables capture of `addr` and a latch update |
| addr | input | 9 | Entry address {row[6:0], logical row[1:0]} |
| uopBus | output | 216 | Three micro-ops in logical order, micro-op 0 in the low bits |

## Verification
A sweep over all 512 entries compares each word against a logical-order reference, so any error in the permutation, the demultiplex or the row decode shows up at the ports. Reads of the four neighbours in one physical row separate a wrong logical-row selection from a wrong row decode. Reads that toggle only the wordline bit separate a wordline error from the other two. Sequences in which `readEn` drops while `addr` keeps changing tell a real hold apart from a latch that leaks. Slice checks on one word pin down where each micro-op sits on the bus.

// File: rtl/ucrom_pkg.sv
package ucrom_pkg;
  localparam int UOP_W     = 72;
  localparam int UOPS      = 3;
  localparam int WORD_W    = UOP_W * UOPS;
  localparam int LROWS     = 4;
  localparam int LR_BITS   = $clog2(LROWS);
  localparam int VIS_ROWS  = 64;
  localparam int VIS_BITS  = $clog2(VIS_ROWS);
  localparam int WL_PER    = 2;
  localparam int ROW_BITS  = VIS_BITS + $clog2(WL_PER);
  localparam int ADDR_W    = ROW_BITS + LR_BITS;
  localparam int BLK_IN    = 16;
  localparam int BLK_OUT   = BLK_IN / LROWS;
  localparam int GROUPS    = WORD_W / BLK_OUT;
  localparam int HALVES    = 2;
  localparam int GRP_HALF  = GROUPS / HALVES;
  localparam int PHYS_COLS = GROUPS * BLK_IN;

  typedef struct packed {
    logic                latchEn;
    logic [VIS_BITS-1:0] visRow;
    logic                wlSel;
    logic [LROWS-1:0]    lrowHot;
  } ucrom_strb_t;

  // Logical content of the mask: one bit per (entry, logical bit)
  function automatic logic logicalBit(input int a, input int i);
    int h;
    h = a * 37 + i * 11 + ((a * i) & 255);
    return ^(h & 32'h1D3);
  endfunction

  function automatic int permOf(input int i, input int mul, input int add);
    return (i * mul + add) % WORD_W;
  endfunction

  function automatic int invPermOf(input int j, input int mul, input int add);
    int res;
    res = 0;
    for (int i = 0; i < WORD_W; i++)
      if (permOf(i, mul, add) == j) res = i;
    return res;
  endfunction

  function automatic logic [WORD_W-1:0] refWord(input int a);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_W; i++) w[i] = logicalBit(a, i);
    return w;
  endfunction
endpackage

// File: rtl/ucrom_ctrl.sv
module ucrom_ctrl
  import ucrom_pkg::*;
(
  input  logic              readEn,
  input  logic [ADDR_W-1:0] addr,
  output ucrom_strb_t       strb
);
  logic [LR_BITS-1:0] lrowField;

  assign lrowField = addr[LR_BITS-1:0];

  always_comb begin
    strb.latchEn = readEn;
    strb.visRow  = addr[ADDR_W-1 -: VIS_BITS];
    strb.wlSel   = addr[LR_BITS];
    for (int l = 0; l < LROWS; l++)
      strb.lrowHot[l] = (lrowField == LR_BITS'(l));
  end
endmodule

// File: rtl/ucrom_datapath.sv
module ucrom_datapath
  import ucrom_pkg::*;
#(
  parameter int PERM_MUL = 25,
  parameter int PERM_ADD = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ucrom_strb_t       strb,
  output logic [WORD_W-1:0] uopBus
);
  logic [ROW_BITS-1:0]  rowAddr;
  logic [PHYS_COLS-1:0] senseCol;
  logic [WORD_W-1:0]    demuxed;
  logic [WORD_W-1:0]    latchQ;

  assign rowAddr = {strb.visRow, strb.wlSel};

  // Two half-arrays share the row address; each holds GRP_HALF column blocks
  for (genvar h = 0; h < HALVES; h++) begin : gHalf
    for (genvar gg = 0; gg < GRP_HALF; gg++) begin : gBlk
      localparam int G = h * GRP_HALF + gg;
      for (genvar k = 0; k < BLK_OUT; k++) begin : gOut
        localparam int J  = G * BLK_OUT + k;
        localparam int IJ = invPermOf(J, PERM_MUL, PERM_ADD);
        for (genvar l = 0; l < LROWS; l++) begin : gCell
          assign senseCol[G*BLK_IN + k*LROWS + l] =
            logicalBit(int'(rowAddr) * LROWS + l, IJ);
        end
        // 16-to-4 per block: keep the column of the selected logical row
        assign demuxed[J] = |(senseCol[G*BLK_IN + k*LROWS +: LROWS] & strb.lrowHot);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchQ <= '0;
    else if (strb.latchEn) latchQ <= demuxed;
  end

  // Unscramble: logical bit i lives in latch column permOf(i)
  for (genvar i = 0; i < WORD_W; i++) begin : gUnscr
    localparam int P = permOf(i, PERM_MUL, PERM_ADD);
    assign uopBus[i] = latchQ[P];
  end
endmodule

// File: rtl/ucrom_top.sv
module ucrom_top
  import ucrom_pkg::*;
#(
  parameter int PERM_MUL = 25,
  parameter int PERM_ADD = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readEn,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] uopBus
);
  ucrom_strb_t strb;

  ucrom_ctrl ctrl_i (
    .readEn (readEn),
    .addr   (addr),
    .strb   (strb)
  );

  ucrom_datapath #(.PERM_MUL(PERM_MUL), .PERM_ADD(PERM_ADD)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .uopBus (uopBus)
  );
endmodule

// File: rtl/ucrom_checker.sv
module ucrom_checker
  import ucrom_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              readEn,
  input logic [ADDR_W-1:0] addr,
  input logic [WORD_W-1:0] uopBus,
  input ucrom_strb_t       strb
);
  always @(negedge clk)
    if (!rstN) assert_reset_clear_R1: assert (uopBus == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !readEn |=> $stable(uopBus));

  assert_content_R3: assert property (@(posedge clk) disable iff (!rstN)
    readEn |=> (uopBus == refWord(int'($past(addr)))));

  assert_lrow_select_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchEn |-> ($countones(strb.lrowHot) == 1));

  assert_addr_known_R2: assert property (@(posedge clk) disable iff (!rstN)
    readEn |-> !$isunknown(addr));
endmodule

bind ucrom_top ucrom_checker chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .readEn (readEn),
  .addr   (addr),
  .uopBus (uopBus),
  .strb   (strb)
);

// File: tb/ucrom_tb_top.sv
module ucrom_tb_top;
  localparam int WW = 216;
  localparam int NV = 12;
  // {readEn, addr}
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 9'd0},   {1'b1, 9'd1},   {1'b1, 9'd2},   {1'b1, 9'd3},
    {1'b1, 9'd4},   {1'b0, 9'd300}, {1'b0, 9'd17},  {1'b1, 9'd511},
    {1'b1, 9'd510}, {1'b1, 9'd255}, {1'b0, 9'd256}, {1'b1, 9'd256}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b1;
  logic          readEn = 1'b0;
  logic [8:0]    addr = '0;
  logic [WW-1:0] uopBus;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ucrom_top dut_i (.clk(clk), .rstN(rstN), .readEn(readEn), .addr(addr), .uopBus(uopBus));

  function automatic logic [WW-1:0] expWord(input int a);
    logic [WW-1:0] w;
    for (int i = 0; i < WW; i++) begin
      int h;
      h = a * 37 + i * 11 + ((a * i) & 255);
      w[i] = ^(h & 32'h1D3);
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readAt(input int a, input string req);
    readEn = 1'b1;
    addr = 9'(a);
    @(negedge clk);
    check(uopBus == expWord(a), req, uopBus, expWord(a));
  endtask

  initial begin
    logic [WW-1:0] last;
    #1 rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(uopBus == '0, "R1 in reset", uopBus, '0);
    rstN = 1'b1;
    addr = 9'd77;
    @(negedge clk);
    check(uopBus == '0, "R1 after release", uopBus, '0);

    // vector table walk
    last = '0;
    for (int v = 0; v < NV; v++) begin
      readEn = VEC[v][9];
      addr = VEC[v][8:0];
      @(negedge clk);
      if (VEC[v][9]) last = expWord(int'(VEC[v][8:0]));
      check(uopBus == last, VEC[v][9] ? "R2 R6 table read" : "R5 table hold", uopBus, last);
    end

    // full sweep, back to back (R3, R6)
    for (int a = 0; a < 512; a++) readAt(a, "R3 sweep");

    // logical rows of one physical row, and the wordline neighbour (R7)
    for (int l = 0; l < 4; l++) readAt(9'h1A8 + l, "R7 logical row");
    readAt(9'h1AC, "R7 wordline neighbour");
    check(expWord(9'h1A8) != expWord(9'h1A9), "R7 distinct rows", expWord(9'h1A8), expWord(9'h1A9));

    // micro-op placement (R4)
    readAt(9'h155, "R4 word");
    for (int k = 0; k < 3; k++) begin
      logic [WW-1:0] e;
      e = expWord(9'h155);
      check(uopBus[72*k +: 72] == e[72*k +: 72], "R4 uop slice",
            WW'(uopBus[72*k +: 72]), WW'(e[72*k +: 72]));
    end

    // hold with changing address (R5)
    last = uopBus;
    readEn = 1'b0;
    for (int c = 0; c < 4; c++) begin
      addr = 9'(c * 97 + 3);
      @(negedge clk);
      check(uopBus == last, "R5 hold", uopBus, last);
    end

    // reset mid-run (R1)
    readEn = 1'b1;
    addr = 9'd9;
    #2 rstN = 1'b0;
    @(negedge clk);
    check(uopBus == '0, "R1 mid-run reset", uopBus, '0);
    rstN = 1'b1;
    readEn = 1'b0;
    @(negedge clk);
    check(uopBus == '0, "R1 stays clear", uopBus, '0);
    readAt(9, "R2 after reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule